// File: doc/BRIEF.md
# Boot shadow-ROM address decoder

This block sits beside an 8-bit CPU with a 64 KiB address space. It turns each bus cycle into one of four chip selects: a 16 KiB boot ROM, the 32 KiB RAM behind the lower half of the map, the RAM in the upper half, and a 256-byte I/O page at the very top. The selects follow the address and strobes combinationally. Two state bits shape the decode: a boot flag and a saturating read counter.

While the boot flag is set, the bottom 16 KiB is split by direction. Reads select the ROM and writes select the lower RAM at the same offset. Firmware can therefore copy itself into RAM by reading each byte and writing it straight back. Writing 1 to a fixed control address in the I/O page then retires the ROM.

A strap input picks an overlay style instead. In that style, the ROM answers only reads inside the reset-vector page, and only for the first few reads after reset. Once that count is reached, RAM takes over on its own. There is no data stream at this block's edge, so the pins carry no valid/ready handshake. The strobes are plain level signals.

Top module: `boot_decoder`

## Requirements
- R1: After reset the boot flag is set. In split style (`ovl_mode`=0), a read at any address 0x0000–0x3FFF selects the ROM.
- R2: While the boot flag is set in split style, a write to 0x0000–0x3FFF selects the lower RAM and never the ROM, so a read-then-write-back loop copies the ROM into RAM.
- R3: Reads and writes at 0x4000–0x7FFF select the lower RAM in every mode and state.
- R4: Addresses 0x8000–0xFEFF select the upper RAM, and 0xFF00–0xFFFF select I/O, in every mode and state. This includes writes to the control address.
- R5: A write to 0xFF80 with `ctl_bit`=1 clears the boot flag from the next cycle on. After that, reads and writes at 0x0000–0x3FFF select the lower RAM.
- R6: A write to 0xFF80 with `ctl_bit`=0 leaves the boot flag unchanged. Once the flag is cleared, only reset sets it again.
- R7: In overlay style (`ovl_mode`=1), a read in the vector page 0x0000–0x00FF selects the ROM while fewer than N (default 4) reads have completed since reset. Completion is the falling edge of `rd`, at any address. Other low reads, and all writes, select the lower RAM.
- R8: In overlay style, once N reads have completed, vector-page reads select the lower RAM. The count saturates at N.
- R9: At most one select is active. None is active when both strobes are low or both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets boot flag, clears read count |
| ovl_mode | input | 1 | Boot style strap: 0 split by direction, 1 vector overlay |
| addr | input | 16 | CPU address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| ctl_bit | input | 1 | Data bit 0, sampled by writes to the control address |
| rom_cs | output | 1 | Boot ROM select |
| lo_ram_cs | output | 1 | Lower 32 KiB RAM select |
| hi_ram_cs | output | 1 | Upper RAM select |
| io_cs | output | 1 | I/O page select |

## Verification
The assertions check these properties on every cycle:
- at most one select is active, and none when the strobes are idle or both asserted;
- the ROM appears only for reads in the bottom 16 KiB;
- the middle window, upper RAM and I/O page decode the same way regardless of mode or state.

Only the bench's sequences can show that the stateful behaviour is right:
- the write-back copy pattern routes each read to ROM and each write to RAM;
- the control write retires the ROM only when the data bit is 1, and reset brings it back;
- the overlay releases the vector page after exactly N completed reads.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [1:0] {
    RG_BOOT = 2'd0,
    RG_MID  = 2'd1,
    RG_HI   = 2'd2,
    RG_IO   = 2'd3
  } region_e;

  typedef struct packed {
    logic rom;
    logic lo_ram;
    logic hi_ram;
    logic io;
  } sel_t;
endpackage

// File: rtl/bd_region.sv
module bd_region
  import bd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_W   = 8,
  parameter int VEC_LOG2 = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic              in_vec
);
  localparam int HI_W = ADDR_W - PAGE_W;

  always_comb begin
    if (!addr[ADDR_W-1]) begin
      region = addr[ADDR_W-2] ? RG_MID : RG_BOOT;
    end else if (&addr[ADDR_W-1:PAGE_W]) begin
      region = RG_IO;
    end else begin
      region = RG_HI;
    end
  end

  assign in_vec = (addr[ADDR_W-1:VEC_LOG2] == '0);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = addr[ADDR_W-1:PAGE_W];
endmodule

// File: rtl/bd_boot_ctl.sv
module bd_boot_ctl #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF80,
  parameter int              OVL_READS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              ctl_bit,
  output logic              boot,
  output logic              ovl_open
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot <= 1'b1;
    end else if (wr && !rd && addr == CTRL_ADDR && ctl_bit) begin
      boot <= 1'b0;
    end
  end

  generate
    if (OVL_READS == 0) begin : g_no_ovl
      assign ovl_open = 1'b0;
      logic unused_rd;
      assign unused_rd = rd;
    end else begin : g_ovl
      localparam int CW = $clog2(OVL_READS + 1);
      localparam logic [CW-1:0] LIMIT = CW'(OVL_READS);
      logic          rd_q;
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q <= 1'b0;
          cnt  <= '0;
        end else begin
          rd_q <= rd;
          if (rd_q && !rd && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      assign ovl_open = (cnt < LIMIT);
    end
  endgenerate
endmodule

// File: rtl/bd_select.sv
module bd_select
  import bd_pkg::*;
(
  input  region_e region,
  input  logic    in_vec,
  input  logic    rd,
  input  logic    wr,
  input  logic    boot,
  input  logic    ovl_mode,
  input  logic    ovl_open,
  output sel_t    sel
);
  logic access;
  logic rom_hit;

  assign access = rd ^ wr;

  always_comb begin
    rom_hit = 1'b0;
    if (access && rd && region == RG_BOOT && boot) begin
      rom_hit = ovl_mode ? (in_vec && ovl_open) : 1'b1;
    end
    sel.rom    = rom_hit;
    sel.lo_ram = access && !rom_hit && (region == RG_BOOT || region == RG_MID);
    sel.hi_ram = access && region == RG_HI;
    sel.io     = access && region == RG_IO;
  end
endmodule

// File: rtl/boot_decoder.sv
module boot_decoder
  import bd_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                PAGE_W    = 8,
  parameter int                VEC_LOG2  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF80,
  parameter int                OVL_READS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ovl_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  input  logic              ctl_bit,
  output logic              rom_cs,
  output logic              lo_ram_cs,
  output logic              hi_ram_cs,
  output logic              io_cs
);
  region_e region;
  logic    in_vec;
  logic    boot;
  logic    ovl_open;
  sel_t    sel;

  bd_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VEC_LOG2(VEC_LOG2)) u_region (
    .addr(addr), .region(region), .in_vec(in_vec)
  );

  bd_boot_ctl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .OVL_READS(OVL_READS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
    .ctl_bit(ctl_bit), .boot(boot), .ovl_open(ovl_open)
  );

  bd_select u_sel (
    .region(region), .in_vec(in_vec), .rd(rd), .wr(wr), .boot(boot),
    .ovl_mode(ovl_mode), .ovl_open(ovl_open), .sel(sel)
  );

  assign rom_cs    = sel.rom;
  assign lo_ram_cs = sel.lo_ram;
  assign hi_ram_cs = sel.hi_ram;
  assign io_cs     = sel.io;
endmodule

// File: rtl/bd_chk.sv
module bd_chk #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd,
  input logic              wr,
  input logic              rom_cs,
  input logic              lo_ram_cs,
  input logic              hi_ram_cs,
  input logic              io_cs
);
  logic [3:0] sels;
  logic       one_strobe;
  assign sels       = {rom_cs, lo_ram_cs, hi_ram_cs, io_cs};
  assign one_strobe = rd ^ wr;

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels));

  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !one_strobe |-> sels == 4'b0000);

  a_r2_rom_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    rom_cs |-> (rd && !wr && addr[ADDR_W-1:ADDR_W-2] == 2'b00));

  a_r3_mid_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (one_strobe && addr[ADDR_W-1:ADDR_W-2] == 2'b01) |-> lo_ram_cs);

  a_r4_io_page: assert property (@(posedge clk) disable iff (!rst_n)
    (one_strobe && &addr[ADDR_W-1:PAGE_W]) |-> io_cs);

  a_r4_hi_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (one_strobe && addr[ADDR_W-1] && !(&addr[ADDR_W-1:PAGE_W])) |-> hi_ram_cs);
endmodule

bind boot_decoder bd_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
  .rom_cs(rom_cs), .lo_ram_cs(lo_ram_cs), .hi_ram_cs(hi_ram_cs), .io_cs(io_cs)
);

// File: tb/tb_boot_decoder.sv
module tb_boot_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {rd, wr, addr, expected {rom, lo, hi, io}} in split style with boot flag set
  localparam logic [21:0] VECS [NVEC] = '{
    {1'b1, 1'b0, 16'h0000, 4'b1000},
    {1'b1, 1'b0, 16'h3FFF, 4'b1000},
    {1'b0, 1'b1, 16'h0000, 4'b0100},
    {1'b0, 1'b1, 16'h3FFF, 4'b0100},
    {1'b1, 1'b0, 16'h4000, 4'b0100},
    {1'b0, 1'b1, 16'h7FFF, 4'b0100},
    {1'b1, 1'b0, 16'h8000, 4'b0010},
    {1'b0, 1'b1, 16'hFEFF, 4'b0010},
    {1'b1, 1'b0, 16'hFF00, 4'b0001},
    {1'b0, 1'b1, 16'hFFFF, 4'b0001},
    {1'b0, 1'b0, 16'h0000, 4'b0000},
    {1'b1, 1'b1, 16'h1234, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ovl_mode = 1'b0;
  logic [15:0] addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic        ctl_bit = 1'b0;
  logic        rom_cs, lo_ram_cs, hi_ram_cs, io_cs;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  boot_decoder dut (
    .clk(clk), .rst_n(rst_n), .ovl_mode(ovl_mode), .addr(addr), .rd(rd),
    .wr(wr), .ctl_bit(ctl_bit), .rom_cs(rom_cs), .lo_ram_cs(lo_ram_cs),
    .hi_ram_cs(hi_ram_cs), .io_cs(io_cs)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input logic [3:0] exp, input string req);
    n_chk++;
    if ({rom_cs, lo_ram_cs, hi_ram_cs, io_cs} !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h got=%b exp=%b", req, addr,
               {rom_cs, lo_ram_cs, hi_ram_cs, io_cs}, exp);
    end
  endtask

  task automatic op(input logic r, input logic w, input logic [15:0] a,
                    input logic c, input logic [3:0] exp, input string req);
    @(negedge clk);
    rd = r; wr = w; addr = a; ctl_bit = c;
    #1 check(exp, req);
    @(negedge clk);
    rd = 1'b0; wr = 1'b0; ctl_bit = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0; ovl_mode = mode; rd = 1'b0; wr = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset(1'b0);
    #1 check(4'b0000, "R1 idle after reset");
    op(1'b1, 1'b0, 16'h0100, 1'b0, 4'b1000, "R1 boot read");

    for (int i = 0; i < NVEC; i++) begin
      op(VECS[i][21], VECS[i][20], VECS[i][19:4], 1'b0, VECS[i][3:0],
         "R2/R3/R4/R9 vector");
    end

    for (int i = 0; i < 3; i++) begin
      op(1'b1, 1'b0, 16'(i * 16'h1555), 1'b0, 4'b1000, "R2 copy read");
      op(1'b0, 1'b1, 16'(i * 16'h1555), 1'b0, 4'b0100, "R2 copy write");
    end

    op(1'b0, 1'b1, 16'hFF80, 1'b0, 4'b0001, "R4 ctl write io");
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b1000, "R6 zero write ignored");
    op(1'b0, 1'b1, 16'hFF80, 1'b1, 4'b0001, "R5 ctl write io");
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b0100, "R5 read after exit");
    op(1'b1, 1'b0, 16'h3FFF, 1'b0, 4'b0100, "R5 read after exit top");
    op(1'b0, 1'b1, 16'h2000, 1'b0, 4'b0100, "R5 write after exit");
    op(1'b0, 1'b1, 16'hFF80, 1'b0, 4'b0001, "R6 zero write after exit");
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b0100, "R6 stays cleared");
    op(1'b1, 1'b0, 16'h4000, 1'b0, 4'b0100, "R3 mid after exit");
    op(1'b0, 1'b1, 16'hFF00, 1'b0, 4'b0001, "R4 io after exit");

    do_reset(1'b0);
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b1000, "R6 reset restores boot");

    do_reset(1'b1);
    op(1'b1, 1'b0, 16'h0200, 1'b0, 4'b0100, "R7 non-vector read");
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b1000, "R7 vector read 2");
    op(1'b0, 1'b1, 16'h0000, 1'b0, 4'b0100, "R7 vector write");
    op(1'b1, 1'b0, 16'h00FF, 1'b0, 4'b1000, "R7 vector read 3");
    op(1'b1, 1'b0, 16'h0010, 1'b0, 4'b1000, "R7 vector read 4");
    op(1'b1, 1'b0, 16'h0000, 1'b0, 4'b0100, "R8 vector read 5");
    op(1'b1, 1'b0, 16'h0001, 1'b0, 4'b0100, "R8 saturated");
    op(1'b1, 1'b0, 16'h8000, 1'b0, 4'b0010, "R4 hi in overlay");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule